// File: doc/BRIEF.md
# Exhaustive Block Motion Search Engine

This block finds where a 16x16 macroblock of 8-bit pixels best fits inside a square reference window that surrounds the macroblock's own position. The window reaches P pixels past the block on each side, so the engine tries every integer displacement from -P to +P in both axes. That is (2P+1)^2 candidates. For each candidate it sums the absolute pixel differences and keeps the displacement with the smallest sum.

The current macroblock and the reference window are held in two internal pixel stores, which are filled through a single write port before a search starts. A one-cycle `start` launches the search. The datapath compares eight pixel pairs per clock, so each candidate takes 32 cycles. When the search ends, the engine reports the winning displacement and its SAD and gives a one-cycle `done`. It also raises `matched` when the winning SAD is no greater than a tolerance that was captured at start. When `matched` is low, the caller should code the block without prediction.

Top module: `motion_search`

## Requirements
- R1: When `wr_en` is high and the engine is idle, `wr_data` is stored. With `wr_sel`=0 it goes to the current block at address row*16+col. With `wr_sel`=1 it goes to the reference window at address row*(16+2P)+col. Writes made while `busy` is high are ignored.
- R2: After reset, `busy`, `done`, `matched`, `min_sad`, `mv_x` and `mv_y` are all zero.
- R3: For an offset (dx,dy), the candidate SAD is the sum over r,c in 0..15 of |cur[r][c] - ref[r+dy+P][c+dx+P]|. The engine reports the smallest candidate SAD on `min_sad`, and its offset on `mv_x`=dx and `mv_y`=dy, both in signed two's complement.
- R4: The reported vector components always lie within -P..+P.
- R5: `matched` is 1 exactly when `min_sad` is less than or equal to the `tol` value sampled in the cycle that `start` was accepted.
- R6: When several candidates share the minimum SAD, the engine reports the one that comes first in raster order. The vertical offset is the outer loop and the horizontal offset is the inner loop, each ascending from -P.
- R7: `done` is high for exactly one cycle, (2P+1)^2*32 clock edges after the edge that accepted `start`. `busy` falls on that same edge.
- R8: A search begins only on `start` while idle. A `start` asserted during a search has no effect on the result or on the timing.
- R9: SAD sums up to 256*255 = 65280 are reported without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pixel write strobe |
| wr_sel | input | 1 | Selects the store: 0 = current block, 1 = reference window |
| wr_addr | input | clog2((16+2P)^2) | Linear pixel address |
| wr_data | input | 8 | Pixel value |
| tol | input | 16 | Match tolerance, sampled at start |
| start | input | 1 | Launches a search when idle |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| mv_x | output | clog2(2P+1)+1 | Horizontal displacement of the best candidate, signed |
| mv_y | output | clog2(2P+1)+1 | Vertical displacement of the best candidate, signed |
| min_sad | output | 16 | SAD of the best candidate |
| matched | output | 1 | Best SAD is within tolerance |

## Verification
The hardest case to reach from the ports is a tie: hashed pixel data almost never gives two candidates the same SAD. The bench forces ties by loading an all-zero reference window and a uniform current block, which makes every candidate score identically. It then checks that the first candidate in raster order wins. Exact hits at the corner displacements and at interior displacements are produced by copying a sub-square of the hashed window into the current block. Flipping the lowest bit of every copied pixel places the winner at a SAD of exactly 256, which lets the tolerance comparison be tested one step on either side of that value.

// File: rtl/motion_search.sv
module motion_search #(
  parameter int P = 7,
  localparam int W = 16 + 2*P,
  localparam int VW = $clog2(2*P+1) + 1,
  localparam int AW = $clog2(W*W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [AW-1:0]        wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [15:0]          tol,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic signed [VW-1:0] mv_x,
  output logic signed [VW-1:0] mv_y,
  output logic [15:0]          min_sad,
  output logic                 matched
);
  localparam logic signed [VW-1:0] PMAX = VW'(P);
  localparam logic signed [VW-1:0] PMIN = -PMAX;

  logic [7:0] cur_m [256];
  logic [7:0] ref_m [W*W];
  logic signed [VW-1:0] cx, cy;
  logic [4:0]  step;
  logic [15:0] acc, tol_q, cand, best_next;
  logic [10:0] step_sum;
  logic        first, take;

  always_ff @(posedge clk) begin
    if (wr_en && !busy) begin
      if (wr_sel) begin
        if (int'(wr_addr) < W*W) ref_m[wr_addr] <= wr_data;
      end else if (int'(wr_addr) < 256) begin
        cur_m[wr_addr[7:0]] <= wr_data;
      end
    end
  end

  always_comb begin
    step_sum = '0;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] cp, rp;
      logic [AW-1:0] ra;
      cp = cur_m[{step, 3'(k)}];
      ra = AW'((int'(step[4:1]) + int'(cy) + P) * W + int'(step[0]) * 8 + k + int'(cx) + P);
      rp = ref_m[ra];
      step_sum = step_sum + 11'((cp > rp) ? cp - rp : rp - cp);
    end
  end

  assign cand      = acc + 16'(step_sum);
  assign first     = (cx == PMIN) && (cy == PMIN);
  assign take      = first || (cand < min_sad);
  assign best_next = take ? cand : min_sad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; matched <= 1'b0;
      mv_x <= '0; mv_y <= '0; min_sad <= '0;
      cx <= '0; cy <= '0; step <= '0; acc <= '0; tol_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; cx <= PMIN; cy <= PMIN;
          step <= '0; acc <= '0; tol_q <= tol;
        end
      end else begin
        step <= step + 5'd1;
        if (step == 5'd31) begin
          acc <= '0;
          if (take) begin
            min_sad <= cand; mv_x <= cx; mv_y <= cy;
          end
          if (cx == PMAX) begin
            cx <= PMIN;
            if (cy == PMAX) begin
              busy <= 1'b0; done <= 1'b1;
              matched <= (best_next <= tol_q);
            end else begin
              cy <= cy + 1'b1;
            end
          end else begin
            cx <= cx + 1'b1;
          end
        end else begin
          acc <= cand;
        end
      end
    end
  end
endmodule

module motion_search_chk #(
  parameter int P = 7,
  localparam int VW = $clog2(2*P+1) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic signed [VW-1:0] mv_x,
  input logic signed [VW-1:0] mv_y,
  input logic [15:0]          min_sad,
  input logic                 matched,
  input logic [15:0]          tol_q
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_mv_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(mv_x) >= -P && int'(mv_x) <= P && int'(mv_y) >= -P && int'(mv_y) <= P));
  assert_match_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (matched == (min_sad <= tol_q)));
  assert_start_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind motion_search motion_search_chk #(.P(P)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mv_x(mv_x), .mv_y(mv_y), .min_sad(min_sad), .matched(matched), .tol_q(tol_q)
);

// File: tb/sim_motion_search.sv
`timescale 1ns/1ps
module sim_motion_search;
  localparam int P = 7;
  localparam int W = 16 + 2*P;
  localparam int VW = $clog2(2*P+1) + 1;
  localparam int AW = $clog2(W*W);
  localparam int LAT = (2*P+1)*(2*P+1)*32;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_sel = 0, start = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [15:0] tol = '0;
  logic busy, done, matched;
  logic signed [VW-1:0] mv_x, mv_y;
  logic [15:0] min_sad;
  int errors = 0, checks = 0;
  logic [7:0] refb [W*W];

  always #2.5 clk = ~clk;

  motion_search #(.P(P)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .tol(tol), .start(start), .busy(busy), .done(done),
    .mv_x(mv_x), .mv_y(mv_y), .min_sad(min_sad), .matched(matched));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load_ref_hash();
    for (int r = 0; r < W; r++)
      for (int c = 0; c < W; c++) begin
        refb[r*W+c] = 8'(r*131 + c*71 + r*c*29 + (r^c)*13 + 7);
        wr(1, r*W+c, refb[r*W+c]);
      end
  endtask

  task automatic load_ref_const(input logic [7:0] v);
    for (int i = 0; i < W*W; i++) begin refb[i] = v; wr(1, i, v); end
  endtask

  task automatic load_cur_copy(input int dx, input int dy, input logic [7:0] flip);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        wr(0, r*16+c, refb[(r+dy+P)*W + c+dx+P] ^ flip);
  endtask

  task automatic load_cur_const(input logic [7:0] v);
    for (int i = 0; i < 256; i++) wr(0, i, v);
  endtask

  task automatic run_search(input logic [15:0] t, input bit poke, output int lat);
    int n = 0;
    @(negedge clk); tol = t; start = 1;
    @(posedge clk); @(negedge clk); start = 0;
    while (!done && n < 20000) begin
      @(posedge clk); @(negedge clk); n++;
      if (poke && n == 100) begin start = 1; wr_en = 1; wr_sel = 0; wr_addr = '0; wr_data = 8'hA5; end
      if (poke && n == 101) begin start = 0; wr_en = 0; end
    end
    if (!done) begin errors++; checks++; $display("FAIL R7: search never finished actual=%0d expected=%0d", n, LAT); end
    lat = n;
  endtask

  task automatic t_reset();
    chk("R2 busy", busy, 0); chk("R2 done", done, 0); chk("R2 matched", matched, 0);
    chk("R2 min_sad", min_sad, 0); chk("R2 mv_x", int'(mv_x), 0); chk("R2 mv_y", int'(mv_y), 0);
  endtask

  task automatic t_exact(input int dx, input int dy);
    int lat;
    load_cur_copy(dx, dy, 8'h00);
    run_search(16'd0, 0, lat);
    chk("R3 exact sad", min_sad, 0);
    chk("R3 mv_x", int'(mv_x), dx); chk("R3 mv_y", int'(mv_y), dy);
    chk("R4 mv_x range", int'(mv_x) >= -P && int'(mv_x) <= P, 1);
    chk("R7 latency", lat, LAT);
    @(negedge clk); chk("R7 done one cycle", done, 0); chk("R7 busy low", busy, 0);
  endtask

  task automatic t_tolerance();
    int lat;
    load_cur_copy(-4, 5, 8'h01);
    run_search(16'd256, 0, lat);
    chk("R5 sad 256", min_sad, 256); chk("R5 mv_x", int'(mv_x), -4); chk("R5 mv_y", int'(mv_y), 5);
    chk("R5 matched at tol=256", matched, 1);
    run_search(16'd255, 0, lat);
    chk("R5 unmatched at tol=255", matched, 0);
  endtask

  task automatic t_ignore_busy();
    int lat;
    load_cur_copy(2, 1, 8'h00);
    run_search(16'd0, 1, lat);
    chk("R8 latency with extra start", lat, LAT);
    chk("R8 sad", min_sad, 0); chk("R8 mv_x", int'(mv_x), 2);
    run_search(16'd0, 0, lat);
    chk("R1 busy write ignored sad", min_sad, 0);
    chk("R1 busy write ignored mv_y", int'(mv_y), 1);
    @(negedge clk); repeat (20) @(negedge clk);
    chk("R8 no spontaneous search", busy, 0);
  endtask

  task automatic t_tie_and_max();
    int lat;
    load_ref_const(8'd0);
    load_cur_const(8'd10);
    run_search(16'd3000, 0, lat);
    chk("R6 tie sad", min_sad, 2560);
    chk("R6 tie mv_x", int'(mv_x), -P); chk("R6 tie mv_y", int'(mv_y), -P);
    chk("R5 matched tie", matched, 1);
    load_cur_const(8'd255);
    run_search(16'd0, 0, lat);
    chk("R9 max sad", min_sad, 65280);
    chk("R9 mv_x", int'(mv_x), -P);
    chk("R1 store update", matched, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    load_ref_hash();
    t_exact(3, -2);
    t_exact(-P, -P);
    t_exact(P, P);
    t_exact(0, 0);
    t_tolerance();
    t_ignore_busy();
    t_tie_and_max();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule